// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Pipeline Flush

This block is the fetch and execute timing controller of a small microcontroller core with 14-bit instruction words. It divides the input clock into instruction cycles of four phases, Q1 to Q4, and brings the phases out as one-hot strobes. During each instruction cycle it fetches the word at the program counter, and the word fetched in the previous cycle executes at the same time.

When the executing word changes the flow of the program, the already-fetched word is dropped. The following instruction cycle then runs as a forced no-operation, and `flush_o` is high for that cycle. Three kinds of word change the flow: a jump, a subroutine call, and a return. A skip-class test whose result flag is true has the same effect.

Jump and call targets are formed from an 11-bit immediate and the bits of an external high latch, which supply the upper program counter bits. Return addresses are kept in a small circular hardware stack.

Top module: `icyc_sequencer`

## Requirements
- R1: `q_o` is one-hot and steps Q1, Q2, Q3, Q4 (bit 0 to bit 3) and then back to Q1. One instruction cycle lasts four clocks. `pc_o`, `exec_word_o` and `flush_o` change only on the edge that ends Q4.
- R2: While `rst_n` is low, `q_o` is Q1, `pc_o` is 0 and `flush_o` is 1. The first cycle after reset is therefore a flush cycle.
- R3: In a cycle with no redirect, the next cycle has `pc_o` equal to the old value plus 1. Its `exec_word_o` is the word that `instr_i` held at the end of Q4, and `flush_o` is 0.
- R4: A jump word, with bits 13:11 equal to 101, executes in a non-flushed cycle. In the next cycle, `flush_o` is 1 and `pc_o` is `{pc_hi_i, word[10:0]}`.
- R5: A call word, with bits 13:11 equal to 100, behaves like a jump. It also pushes the return address, which is the call's address plus 1, onto the return stack.
- R6: A return word is either 0x0008, or has bits 13:10 equal to 1101. It pops the top of the stack into `pc_o` and sets `flush_o` for the next cycle.
- R7: The skip-class words are those with bits 13:8 equal to 001011 or 001111, and those with bits 13:10 equal to 0110 or 0111. For these words, `skip_i` is sampled at the end of Q4. If it is 1, the next cycle is flushed and `pc_o` advances by one.
- R8: `skip_i` has no effect on the PC or on `flush_o` when the executing word is not skip-class.
- R9: A word that sits in a flushed cycle does not execute. A jump, call, return or skip word there causes no redirect, no stack change and no further flush.
- R10: The return stack holds 8 entries and is circular. A ninth push overwrites the oldest entry. Pops return addresses in last-in, first-out order, and the stack pointer wraps past the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 14 | Word read from program memory at `pc_o` |
| skip_i | input | 1 | Skip condition result from the ALU |
| pc_hi_i | input | 2 | High latch bits used above the 11-bit target |
| q_o | output | 4 | One-hot phase strobes Q1..Q4 |
| pc_o | output | 13 | Program counter (address being fetched) |
| exec_word_o | output | 14 | Word executing in the current cycle |
| flush_o | output | 1 | Current cycle is a forced no-operation |

## Verification
The bench runs a reference model of the sequencer. It attacks these cases:

- **Redirect timing.** A word that redirects must flush exactly the next cycle. A design that flushed late, or not at all, would execute the word after a jump.
- **Redirect words in a flushed slot.** A jump, call or skip word placed in a flushed slot must do nothing. A design that executed it would jump, or push onto the stack, a second time.
- **`skip_i` on non-skip words.** The flag is held high while other words execute. A design that did not qualify it would skip spuriously.
- **Stack wrap.** A chain of nine calls and the returns that follow check the wrap-around. A stack that saturated would return to the wrong address.
- **High latch.** A non-zero high latch checks that the upper target bits are taken from `pc_hi_i`.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
  localparam int IW    = 14;
  localparam int IMM_W = 11;

  typedef enum logic [2:0] {
    CLS_PLAIN,
    CLS_GOTO,
    CLS_CALL,
    CLS_RET,
    CLS_SKIP
  } cls_e;

  // Flow class of one instruction word
  function automatic cls_e classify(input logic [IW-1:0] w);
    cls_e c;
    c = CLS_PLAIN;
    if (w[13:11] == 3'b101)                              c = CLS_GOTO;
    else if (w[13:11] == 3'b100)                         c = CLS_CALL;
    else if (w == 14'h0008 || w[13:10] == 4'b1101)       c = CLS_RET;
    else if (w[13:11] == 3'b011)                         c = CLS_SKIP; // bit tests
    else if (w[13:8] == 6'b001011 || w[13:8] == 6'b001111) c = CLS_SKIP; // dec/inc tests
    return c;
  endfunction
endpackage

// File: rtl/icyc_phase.sv
module icyc_phase #(
  parameter int N_PH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [N_PH-1:0] q_o,
  output logic            cyc_end_o
);
  localparam int PW = $clog2(N_PH);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (cnt == PW'(N_PH - 1))    cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < N_PH; g++) begin : g_strobe
    assign q_o[g] = (cnt == PW'(g));
  end

  assign cyc_end_o = q_o[N_PH-1];

  // R1
  ph_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o[N_PH-1] |=> q_o[0]);
  // R1
  ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o[0] |=> q_o[1]);
endmodule

// File: rtl/icyc_decode.sv
module icyc_decode
  import icyc_pkg::*;
(
  input  logic [IW-1:0]    word_i,
  output cls_e             cls_o,
  output logic [IMM_W-1:0] imm_o
);
  assign cls_o = classify(word_i);
  assign imm_o = word_i[IMM_W-1:0];
endmodule

// File: rtl/icyc_stack.sv
module icyc_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);
  localparam int SPW = $clog2(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_i) begin
      mem[sp] <= din_i;
      sp      <= sp + 1'b1;
    end else if (pop_i) begin
      sp <= sp - 1'b1;
    end
  end

  assign top_o = mem[sp - 1'b1];

  // R5
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(din_i));
  // R10
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
  import icyc_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int STK_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [13:0]           instr_i,
  input  logic                  skip_i,
  input  logic [PC_W-IMM_W-1:0] pc_hi_i,
  output logic [3:0]            q_o,
  output logic [PC_W-1:0]       pc_o,
  output logic [13:0]           exec_word_o,
  output logic                  flush_o
);
  localparam int HI_W = PC_W - IMM_W;

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] jump_target(input logic [HI_W-1:0] hi,
                                                  input logic [IMM_W-1:0] k);
    return {hi, k};
  endfunction

  logic            cyc_end;
  cls_e            cls;
  logic [IMM_W-1:0] imm;
  logic [PC_W-1:0] pc_r, pc_next, stk_top;
  logic [IW-1:0]   ir_r;
  logic            flush_r;

  // named events for the assertions
  logic take, goto_ev, call_ev, ret_ev, skip_ev, redirect_ev;

  icyc_phase #(.N_PH(4)) u_phase (
    .clk(clk), .rst_n(rst_n), .q_o(q_o), .cyc_end_o(cyc_end)
  );

  icyc_decode u_dec (.word_i(ir_r), .cls_o(cls), .imm_o(imm));

  icyc_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(call_ev), .pop_i(ret_ev),
    .din_i(pc_r), .top_o(stk_top)
  );

  assign take        = cyc_end && !flush_r;
  assign goto_ev     = take && (cls == CLS_GOTO);
  assign call_ev     = take && (cls == CLS_CALL);
  assign ret_ev      = take && (cls == CLS_RET);
  assign skip_ev     = take && (cls == CLS_SKIP) && skip_i;
  assign redirect_ev = goto_ev || call_ev || ret_ev || skip_ev;

  always_comb begin
    if (ret_ev)                  pc_next = stk_top;
    else if (goto_ev || call_ev) pc_next = jump_target(pc_hi_i, imm);
    else                         pc_next = pc_step(pc_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_r    <= '0;
      ir_r    <= '0;
      flush_r <= 1'b1;
    end else if (cyc_end) begin
      pc_r    <= pc_next;
      ir_r    <= instr_i;
      flush_r <= redirect_ev;
    end
  end

  assign pc_o        = pc_r;
  assign exec_word_o = ir_r;
  assign flush_o     = flush_r;

  // R4 R5 R6 R7
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_ev |=> flush_o);
  // R3 R8
  plain_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !redirect_ev) |=> !flush_o);
  // R1
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_o[3] |=> $stable(pc_o) && $stable(flush_o));
  // R9
  flushed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o[3] && flush_o) |=> !flush_o && pc_o == $past(pc_o) + PC_W'(1));
endmodule

// File: tb/tb_icyc_sequencer.sv
module tb_icyc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] instr_i;
  logic        skip_i;
  logic [1:0]  pc_hi_i = 2'b00;
  logic [3:0]  q_o;
  logic [12:0] pc_o;
  logic [13:0] exec_word_o;
  logic        flush_o;

  always #4 clk = ~clk;

  icyc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .skip_i(skip_i),
    .pc_hi_i(pc_hi_i), .q_o(q_o), .pc_o(pc_o),
    .exec_word_o(exec_word_o), .flush_o(flush_o)
  );

  logic [13:0] prog [64];
  logic        skipv [64];
  logic        skip_pat [256];
  int          tb_cyc = 0, n_seen = 0, ph_exp = 0;
  bit          running = 0, stk_mode = 0;
  int          n_tests = 0, n_fail = 0;

  logic [12:0] exp_pc [$];
  logic        exp_fl [$];
  logic [13:0] exp_w  [$];
  string       exp_tag [$];

  assign instr_i = prog[pc_o[5:0]];
  assign skip_i  = skip_pat[tb_cyc];

  function automatic logic [13:0] w_goto(input int k); return 14'h2800 | 14'(k); endfunction
  function automatic logic [13:0] w_call(input int k); return 14'h2000 | 14'(k); endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin prog[i] = 14'h0000; skipv[i] = 1'b0; end
    for (int i = 0; i < 256; i++) skip_pat[i] = 1'b0;
  endtask

  // Driver: reference model fills the expected queues and the skip pattern
  task automatic build_expect(input int ncyc);
    logic [12:0] m_pc, m_iraddr, stk [8];
    logic [13:0] m_ir, fw;
    logic        m_fl, sv;
    int          sp;
    string       tag;
    m_pc = '0; m_ir = '0; m_fl = 1'b1; m_iraddr = '0; sp = 0; tag = "R2";
    for (int i = 0; i < 8; i++) stk[i] = '0;
    for (int c = 0; c < ncyc; c++) begin
      exp_pc.push_back(m_pc); exp_fl.push_back(m_fl);
      exp_w.push_back(m_ir);  exp_tag.push_back(tag);
      sv = m_fl ? 1'b1 : skipv[m_iraddr[5:0]];
      skip_pat[c] = sv;
      fw = prog[m_pc[5:0]];
      m_iraddr = m_pc;
      if (m_fl) begin
        tag = "R9"; m_pc = m_pc + 13'd1; m_fl = 1'b0;
      end else begin
        casez (m_ir)
          14'b101???????????: begin tag = "R4"; m_pc = {pc_hi_i, m_ir[10:0]}; m_fl = 1'b1; end
          14'b100???????????: begin
            tag = "R5"; stk[sp] = m_pc; sp = (sp + 1) % 8;
            m_pc = {pc_hi_i, m_ir[10:0]}; m_fl = 1'b1;
          end
          14'b00000000001000, 14'b1101??????????: begin
            tag = stk_mode ? "R10" : "R6"; sp = (sp + 7) % 8;
            m_pc = stk[sp]; m_fl = 1'b1;
          end
          14'b011???????????, 14'b001011????????, 14'b001111????????: begin
            tag = "R7"; m_pc = m_pc + 13'd1; m_fl = sv;
          end
          default: begin
            tag = sv ? "R8" : "R3"; m_pc = m_pc + 13'd1; m_fl = 1'b0;
          end
        endcase
      end
      m_ir = fw;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: phase order every clock, cycle results at each Q1
  always @(negedge clk) begin
    if (running) begin
      chk("R1", "phase strobe", 16'(q_o), 16'(4'b0001 << ph_exp));
      ph_exp = (ph_exp + 1) % 4;
      if (q_o[0]) begin
        tb_cyc = n_seen; n_seen++;
        if (exp_pc.size() > 0) begin
          chk(exp_tag[0], "pc", 16'(pc_o), 16'(exp_pc[0]));
          chk(exp_tag[0], "flush", 16'(flush_o), 16'(exp_fl[0]));
          chk(exp_tag[0], "exec word", 16'(exec_word_o), 16'(exp_w[0]));
          void'(exp_pc.pop_front()); void'(exp_fl.pop_front());
          void'(exp_w.pop_front());  void'(exp_tag.pop_front());
        end
      end
    end
  end

  task automatic run_scenario(input int ncyc);
    rst_n = 1'b0; running = 0;
    tb_cyc = 0; n_seen = 0; ph_exp = 0;
    build_expect(ncyc);
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    chk("R2", "reset phase", 16'(q_o), 16'h0001);
    chk("R2", "reset pc", 16'(pc_o), 16'h0000);
    chk("R2", "reset flush", 16'(flush_o), 16'h0001);
    @(posedge clk); #1;
    rst_n = 1'b1; running = 1;
    wait (exp_pc.size() == 0);
    running = 0;
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    // Scenario 1: sequential flow, skips (R3 R7 R8), jump (R4), call/return (R5 R6)
    clear_prog(); stk_mode = 0; pc_hi_i = 2'b00;
    prog[1] = 14'h0700; skipv[1] = 1'b1;   // plain word with skip high: R8
    prog[2] = 14'h1C03; skipv[2] = 1'b1;   // bit test, skip taken: R7
    prog[3] = w_call(40);                  // skipped, must not push: R9
    prog[4] = 14'h0B85; skipv[4] = 1'b0;   // dec test, not taken
    prog[6] = w_goto(10);
    prog[7] = w_goto(50);                  // flushed slot: R9
    prog[10] = w_call(20);
    prog[12] = w_goto(0);
    prog[21] = 14'h0008;                   // return
    run_scenario(30);

    // Scenario 2: non-zero high latch, literal return, flushed call
    clear_prog(); stk_mode = 0; pc_hi_i = 2'b01;
    prog[0] = w_goto(5);
    prog[1] = w_call(3);                   // flushed slot: R9
    prog[5] = w_call(9);
    prog[6] = 14'h1800; skipv[6] = 1'b1;   // skip taken: R7
    prog[7] = w_call(0);                   // skipped
    prog[8] = w_goto(0);
    prog[9] = 14'h3455;                    // literal return: R6
    run_scenario(24);

    // Scenario 3: nine nested calls then returns, stack wrap: R10
    clear_prog(); stk_mode = 1; pc_hi_i = 2'b00;
    for (int k = 0; k <= 8; k++) prog[2*k] = w_call(2*k + 2);
    for (int k = 0; k <= 8; k++) prog[2*k + 1] = 14'h0008;
    prog[18] = 14'h0008;
    run_scenario(60);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule